// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of an external free-running timer count at the moment a chosen transition appears on one of several capture pins. Each pin has its own three-bit control field. The field enables capture on a rising transition, capture on a falling transition, and a sticky interrupt flag on capture. The rising and falling enables may both be set, so that every transition captures. A pin that elsewhere serves as a counting clock is left with its field at zero. The other pins still capture and flag as programmed.

Each pin passes through a two-stage synchroniser and then an edge detector that compares the synchronised level with the previous one. A detected, enabled edge loads the lane's capture register with the timer value. From a pin transition to the updated register there are three clock edges. Software clears a lane's flag by pulsing the matching clear bit. The interrupt output is the OR of all lane flags.

The capture values are plain level outputs that hold until the next capture, so there is no stream handshake and no back-pressure. The control word, the clears, the pins and the interrupt are plain control and status signals.

Top module: `tcap_top`

## Requirements
- R1: The control word holds one 3-bit field per lane. Lane i uses bit 3i as the rising enable, bit 3i+1 as the falling enable and bit 3i+2 as the interrupt enable. The whole word is written when `cfg_we` is high at a clock edge.
- R2: Reset clears all control fields, capture registers and flags, and drives `irq` low. After reset no edge captures until a control word is written.
- R3: With the rising enable set, a 0-to-1 pin change loads that lane's capture register with `tmr_cnt`. The new value appears after the third rising clock edge following the pin change, and not after the second.
- R4: With the falling enable set, a 1-to-0 pin change loads that lane's capture register with `tmr_cnt`, with the same latency.
- R5: With both enables set, every pin change of either direction captures.
- R6: A lane whose rising and falling enables are both zero never loads its capture register and never sets its flag, while the other lanes capture as programmed.
- R7: A capture on a lane with its interrupt enable set raises that lane's flag. The flag stays set until cleared. `irq` is high whenever any flag is set. The interrupt enable alone, with no capture enable, raises nothing.
- R8: A one on `flag_clr[i]` at a clock edge clears flag i, provided that lane has no capture in the same cycle.
- R9: When a capture with the interrupt enabled and a clear of the same lane fall on the same clock edge, the flag stays set.
- R10: A pin held at a constant level causes no further capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 3*N_CAP | Control word, one 3-bit field per lane |
| flag_clr | input | N_CAP | Write-one-to-clear pulses for the lane flags |
| tmr_cnt | input | CNT_W | Current timer count |
| cap_pin | input | N_CAP | Raw, asynchronous capture pins |
| cap_val | output | N_CAP*CNT_W | Capture registers, lane i at bits [i*CNT_W +: CNT_W] |
| irq_flag | output | N_CAP | Sticky per-lane interrupt flags |
| irq | output | 1 | OR of all lane flags |

## Verification
A wrong synchroniser depth or a stale previous-level register shows at the ports as a capture that arrives one edge early or late. It can also show as a capture at a steady level. The bench catches this by checking that the register is unchanged after two edges and updated after three. A wrong enable decode, or a field misaligned between lanes, loads the wrong lane or misses an edge direction within three cycles of the pin change. It shows on `cap_val` and `irq_flag` at once. A wrong priority between clear and event shows one cycle after the collision, as a flag that dropped.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  // One lane's control field, bit 0 first: rising, falling, interrupt.
  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } cap_cfg_t;

  localparam int CFG_W = $bits(cap_cfg_t);
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign evt_o = (rise_en_i & lvl_i & ~prev_q) | (fall_en_i & ~lvl_i & prev_q);

  AST_NO_EVT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_en_i && !fall_en_i) |-> !evt_o); // R6
  AST_NO_EVT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lvl_i) && $stable(prev_q) && !evt_o) |=> (!evt_o || !$stable(rise_en_i) || !$stable(fall_en_i) || !$stable(lvl_i))); // R10
endmodule

// File: rtl/tcap_lane.sv
module tcap_lane
  import tcap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  cap_cfg_t         cfg_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] tmr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  logic             lvl;
  logic             evt;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  tcap_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  tcap_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl),
    .rise_en_i (cfg_i.rise_en),
    .fall_en_i (cfg_i.fall_en),
    .evt_o     (evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_q <= '0;
    else if (evt) cap_q <= tmr_i;
  end

  // A new event outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (evt && cfg_i.irq_en) flag_q <= 1'b1;
    else if (clr_i)               flag_q <= 1'b0;
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  AST_LOAD_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cap_q == $past(tmr_i))); // R3
  AST_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cap_q)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R7
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cfg_i.irq_en && clr_i) |=> flag_q); // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt) |=> !flag_q); // R8
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int N_CAP  = 3,
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_W*N_CAP-1:0] cfg_wdata,
  input  logic [N_CAP-1:0]       flag_clr,
  input  logic [CNT_W-1:0]       tmr_cnt,
  input  logic [N_CAP-1:0]       cap_pin,
  output logic [N_CAP*CNT_W-1:0] cap_val,
  output logic [N_CAP-1:0]       irq_flag,
  output logic                   irq
);
  localparam int CW_TOT = CFG_W * N_CAP;

  logic [CW_TOT-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  generate
    for (genvar i = 0; i < N_CAP; i++) begin : g_lane
      cap_cfg_t lane_cfg;
      assign lane_cfg = cap_cfg_t'(cfg_q[i*CFG_W +: CFG_W]);

      tcap_lane #(.CNT_W(CNT_W), .STAGES(STAGES)) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_pin[i]),
        .cfg_i  (lane_cfg),
        .clr_i  (flag_clr[i]),
        .tmr_i  (tmr_cnt),
        .cap_o  (cap_val[i*CNT_W +: CNT_W]),
        .flag_o (irq_flag[i])
      );
    end
  endgenerate

  assign irq = |irq_flag;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q)); // R1
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wdata))); // R1
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_flag != '0)); // R7
endmodule

// File: tb/sim_tcap_top.sv
module sim_tcap_top;
  localparam int N  = 3;
  localparam int W  = 16;
  localparam int NV = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [3*N-1:0] cfg_wdata = '0;
  logic [N-1:0]   flag_clr = '0;
  logic [W-1:0]   tmr_cnt = '0;
  logic [N-1:0]   cap_pin = '0;
  logic [N*W-1:0] cap_val;
  logic [N-1:0]   irq_flag;
  logic           irq;

  int n_chk = 0;
  int n_err = 0;

  logic [W-1:0] exp_cap [N];
  logic [N-1:0] exp_flag;

  always #2 clk = ~clk;

  tcap_top #(.N_CAP(N), .CNT_W(W), .STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flag_clr(flag_clr), .tmr_cnt(tmr_cnt), .cap_pin(cap_pin),
    .cap_val(cap_val), .irq_flag(irq_flag), .irq(irq)
  );

  // Entry: {cfg[8:0], pins[2:0], timer[15:0], expected load mask[2:0]}
  localparam logic [30:0] VEC [NV] = '{
    {9'b011_010_001, 3'b111, 16'h0100, 3'b101}, // R3 R5 rising on all lanes
    {9'b011_010_001, 3'b000, 16'h0200, 3'b110}, // R4 R5 falling
    {9'b110_000_101, 3'b111, 16'h0300, 3'b001}, // R6 R7 lane1 disabled
    {9'b110_000_101, 3'b000, 16'h0400, 3'b100}, // R4 R6 R7
    {9'b000_000_000, 3'b101, 16'h0500, 3'b000}, // R6 all disabled
    {9'b011_011_011, 3'b010, 16'h0600, 3'b111}, // R5 mixed directions
    {9'b011_011_011, 3'b010, 16'h0700, 3'b000}, // R10 steady pins
    {9'b100_100_100, 3'b101, 16'h0800, 3'b000}  // R7 interrupt enable alone
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++)
      check(req, 32'(cap_val[i*W +: W]), 32'(exp_cap[i]));
    check(req, 32'(irq_flag), 32'(exp_flag));
    check(req, 32'(irq), 32'(|exp_flag));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) exp_cap[i] = '0;
    exp_flag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R2 reset state");

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [8:0]   c;
      logic [2:0]   p;
      logic [15:0]  t;
      logic [2:0]   m;
      {c, p, t, m} = VEC[v];
      cfg_we    = 1'b1;
      cfg_wdata = c;
      tmr_cnt   = t;
      cap_pin   = p;
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      if (v == 0) check("R3 not yet after two edges", 32'(cap_val[0 +: W]), 32'(exp_cap[0]));
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (m[i]) begin
          exp_cap[i] = t;
          if (c[3*i+2]) exp_flag[i] = 1'b1;
        end
      end
      check_all($sformatf("R1 R3 R4 R5 R6 R7 R10 vector %0d", v));
      @(negedge clk);
    end

    // Clear all flags
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = '0;
    exp_flag = '0;
    check_all("R8 clear all flags");

    // Clear and event on the same edge: lane0 falling + irq
    cfg_we    = 1'b1;
    cfg_wdata = 9'b000_000_110;
    tmr_cnt   = 16'h0A0A;
    cap_pin   = 3'b100;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = '0;
    exp_cap[0]  = 16'h0A0A;
    exp_flag[0] = 1'b1;
    check_all("R9 event beats clear");
    @(negedge clk);
    check_all("R7 flag sticky");
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = '0;
    exp_flag = '0;
    check_all("R8 single clear");

    // Reset mid-run clears everything including control
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < N; i++) exp_cap[i] = '0;
    check_all("R2 reset mid-run");
    rst_n = 1'b1;
    cap_pin = 3'b111;
    tmr_cnt = 16'h0BBB;
    repeat (4) @(negedge clk);
    cap_pin = 3'b000;
    repeat (4) @(negedge clk);
    check_all("R2 control zero after reset");

    finish_run();
  end
endmodule